// File: doc/BRIEF.md
# BCD Calendar Clock with Exact-Match Alarm

This block is a real-time clock core that counts seconds, minutes, hours, day of month, month and a two-digit year, all held as packed BCD bytes in 24-hour form. It advances from a slow tick enable, normally a 32.768 kHz strobe, and divides it by `TICKS_PER_SEC` to get one calendar step per second. The calendar handles month lengths and leap Februaries for years 2000 to 2099, where the year byte holds 00 to 99.

Software reaches the block through a byte-wide register port. It can load or read each time field, program a six-field alarm, start or stop the count, poll a busy flag, acknowledge sticky events and enable two interrupt lines. The alarm has no wildcard fields. It fires only when the new time equals the programmed alarm time in every field. The busy flag is high for the last tick period before each step, so software knows when the time bytes are about to move.

Top module: `bcd_rtc_core`

## Requirements
- R1: Time fields sit at byte addresses 0x00 (seconds), 0x04 (minutes), 0x08 (hours), 0x0C (day), 0x10 (month) and 0x14 (year). Alarm fields use the same order at 0x20 to 0x34. All of them read back as written, in packed BCD. After reset the time is 00:00:00, day 01, month 01, year 00.
- R2: Control register 0x40 bit 0 = 1 lets the clock run. With it set, the time steps once for every `TICKS_PER_SEC` cycles on which the tick enable is high. With it clear, the time holds. Status register 0x44 bit 1 reads 1 exactly when bit 0 of the control register is set.
- R3: Seconds and minutes wrap from 59 to 00 and hours from 23 to 00, each carrying into the next field. Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00. BCD digits carry from 9 to the next tens digit.
- R4: Day wraps to 01 after the month length: 31 days, or 30 for months 04, 06, 09 and 11, or 29 for February when the year value is divisible by 4 (year 00 included), or 28 for February otherwise.
- R5: A write to a time field loads that field on the next edge, even on a step edge. The other fields still advance from their old values on that edge.
- R6: Status bit 0 is 1 while the clock runs and the tick counter sits in its last count before a step. It is 0 at all other times, and always 0 while the clock is stopped.
- R7: Status bit 6 is set on the step edge that makes all six time fields equal the six alarm fields. A mismatch in any single field, the year included, leaves it clear.
- R8: Status bit 2 is set on every step edge.
- R9: Writing 1 to status bits 7, 6 or 2 clears those bits. Writing 0 to them leaves them unchanged. Writes to status bits 1 and 0 have no effect.
- R10: Status bit 7 is 1 after reset and is never set again until the next reset.
- R11: The interrupt-enable register 0x48 has bit 3 for the alarm and bit 2 for the timer. The output `alarm_irq` equals status bit 6 AND enable bit 3, and `timer_irq` equals status bit 2 AND enable bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Slow tick strobe, one cycle wide per oscillator period |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe; data is taken on the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational from registers |
| alarm_irq | output | 1 | Alarm interrupt request |
| timer_irq | output | 1 | Once-per-second interrupt request |

## Verification
Every register-visible result is due on the first rising edge after its cause. A write, a step or an acknowledge changes the state on that edge. Read data and the interrupt lines are combinational from those registers, so they are valid in the same cycle.

The bench drives all inputs on falling edges and reads one nanosecond later. It counts tick edges itself: pulse groups are always whole multiples of `TICKS_PER_SEC`, except where a test stops deliberately on the last count. That way the bench always knows the edge on which the step lands. The write-priority test puts its write on exactly that step edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int NFIELD = 6;

   typedef enum logic [2:0] {
      F_SEC = 3'd0,
      F_MIN = 3'd1,
      F_HR  = 3'd2,
      F_DAY = 3'd3,
      F_MON = 3'd4,
      F_YR  = 3'd5
   } field_e;

   // register byte addresses (field i of a group sits at base + 4*i)
   localparam logic [7:0] A_TIME  = 8'h00;
   localparam logic [7:0] A_ALARM = 8'h20;
   localparam logic [7:0] A_CTRL  = 8'h40;
   localparam logic [7:0] A_STAT  = 8'h44;
   localparam logic [7:0] A_IEN   = 8'h48;

   // status and enable bit positions
   localparam int SB_PWRUP = 7;
   localparam int SB_ALARM = 6;
   localparam int SB_SEC   = 2;
   localparam int SB_RUN   = 1;
   localparam int SB_BUSY  = 0;
   localparam int IB_ALARM = 3;
   localparam int IB_TIMER = 2;

   typedef logic [NFIELD-1:0][7:0] cal_t;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [7:0] field_min(input int i);
      return (i == int'(F_DAY) || i == int'(F_MON)) ? 8'h01 : 8'h00;
   endfunction

   function automatic logic [7:0] field_max(input int i);
      case (i)
         0, 1:    return 8'h59;
         2:       return 8'h23;
         4:       return 8'h12;
         5:       return 8'h99;
         default: return 8'h31;
      endcase
   endfunction

   function automatic logic leap_year(input logic [7:0] y);
      logic [6:0] yb;
      yb = 7'({3'b000, y[7:4]} * 7'd10) + {3'b000, y[3:0]};
      return yb[1:0] == 2'b00;
   endfunction

   function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_en_i,
   output logic step_o,
   output logic busy_o
);
   localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

   if (TICKS_PER_SEC < 2) begin : g_bad_ticks
      $error("TICKS_PER_SEC must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          at_last;

   assign at_last = (cnt_q == LAST);
   assign busy_o  = run_i && at_last;
   assign step_o  = run_i && tick_en_i && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (run_i && tick_en_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
   end

   // R6: busy only falls after a tick at the last count or a stop
   p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> ($past(tick_en_i) || !$past(run_i) || !run_i));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step_i,
   input  logic [NFIELD-1:0]   wr_sel_i,
   input  logic [7:0]          wdata_i,
   output cal_t                time_o,
   output cal_t                next_o
);
   cal_t              time_q;
   logic [NFIELD:0]   carry;
   logic [7:0]        dim;

   assign carry[0] = step_i;
   assign dim      = month_len(time_q[F_MON], time_q[F_YR]);

   for (genvar i = 0; i < NFIELD; i++) begin : g_field
      logic [7:0] lim;
      logic       wrap;
      logic [7:0] inc;
      assign lim          = (i == int'(F_DAY)) ? dim : field_max(i);
      assign wrap         = (time_q[i] >= lim);
      assign inc          = wrap ? field_min(i) : bcd_inc(time_q[i]);
      assign carry[i+1]   = carry[i] && wrap;
      assign next_o[i]    = wr_sel_i[i] ? wdata_i : (carry[i] ? inc : time_q[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NFIELD; i++) time_q[i] <= field_min(i);
      end else begin
         time_q <= next_o;
      end
   end

   assign time_o = time_q;

   // R3: seconds wrap on a step from 59
   p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && time_q[F_SEC] == 8'h59 && !wr_sel_i[F_SEC]) |=> (time_q[F_SEC] == 8'h00));

   // R3: month wraps to 01 when carried into at 12
   p_mon_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (carry[F_MON] && time_q[F_MON] == 8'h12 && !wr_sel_i[F_MON]) |=> (time_q[F_MON] == 8'h01));

   // R5: a written field takes the written byte
   p_wr_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel_i[F_SEC] |=> (time_q[F_SEC] == $past(wdata_i)));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_pkg::*;
(
   input  cal_t time_i,
   input  cal_t alarm_i,
   output logic match_o
);
   logic [NFIELD-1:0] eq;

   for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
      assign eq[i] = (time_i[i] == alarm_i[i]);
   end

   assign match_o = &eq;

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_pkg::*;
#(
   parameter int TICKS_PER_SEC = 32768,
   parameter int ADDR_W        = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              alarm_irq,
   output logic              timer_irq
);
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end

   localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
   localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
   localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(A_IEN);

   logic              run_q, ie_al_q, ie_tm_q;
   logic              st_pwr_q, st_al_q, st_sec_q;
   cal_t              alarm_q, time_w, next_w;
   logic [NFIELD-1:0] tsel, asel;
   logic              step, busy, match, stat_wr;

   for (genvar i = 0; i < NFIELD; i++) begin : g_dec
      assign tsel[i] = reg_wr && (reg_addr == ADDR_W'(A_TIME  + 8'(4 * i)));
      assign asel[i] = reg_wr && (reg_addr == ADDR_W'(A_ALARM + 8'(4 * i)));
   end

   assign stat_wr = reg_wr && (reg_addr == AD_STAT);

   rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_q),
      .tick_en_i (tick_en),
      .step_o    (step),
      .busy_o    (busy)
   );

   rtc_calendar u_cal (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_i   (step),
      .wr_sel_i (tsel),
      .wdata_i  (reg_wdata),
      .time_o   (time_w),
      .next_o   (next_w)
   );

   rtc_alarm_match u_match (
      .time_i  (next_w),
      .alarm_i (alarm_q),
      .match_o (match)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm_q  <= '0;
         run_q    <= 1'b0;
         ie_al_q  <= 1'b0;
         ie_tm_q  <= 1'b0;
         st_pwr_q <= 1'b1;
         st_al_q  <= 1'b0;
         st_sec_q <= 1'b0;
      end else begin
         for (int i = 0; i < NFIELD; i++)
            if (asel[i]) alarm_q[i] <= reg_wdata;
         if (reg_wr && reg_addr == AD_CTRL) run_q <= reg_wdata[0];
         if (reg_wr && reg_addr == AD_IEN) begin
            ie_al_q <= reg_wdata[IB_ALARM];
            ie_tm_q <= reg_wdata[IB_TIMER];
         end
         if (stat_wr && reg_wdata[SB_PWRUP]) st_pwr_q <= 1'b0;
         if (step && match)                  st_al_q  <= 1'b1;
         else if (stat_wr && reg_wdata[SB_ALARM]) st_al_q <= 1'b0;
         if (step)                           st_sec_q <= 1'b1;
         else if (stat_wr && reg_wdata[SB_SEC]) st_sec_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = 8'h00;
      for (int i = 0; i < NFIELD; i++) begin
         if (reg_addr == ADDR_W'(A_TIME  + 8'(4 * i))) reg_rdata = time_w[i];
         if (reg_addr == ADDR_W'(A_ALARM + 8'(4 * i))) reg_rdata = alarm_q[i];
      end
      if (reg_addr == AD_CTRL) reg_rdata = {7'b0, run_q};
      if (reg_addr == AD_STAT) reg_rdata = {st_pwr_q, st_al_q, 3'b000, st_sec_q, run_q, busy};
      if (reg_addr == AD_IEN)  reg_rdata = {4'b0000, ie_al_q, ie_tm_q, 2'b00};
   end

   assign alarm_irq = st_al_q && ie_al_q;
   assign timer_irq = st_sec_q && ie_tm_q;

   // R7: the alarm flag only rises on a step edge
   p_alarm_on_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_al_q) |-> $past(step));

   // R9: the alarm flag holds until a one is written to it
   p_alarm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_al_q && !(stat_wr && reg_wdata[SB_ALARM])) |=> st_al_q);

   // R10: power-up flag never returns without a reset
   p_pwrup_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !st_pwr_q |=> !st_pwr_q);

   // R11: timer interrupt only while its enable is set
   p_timer_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timer_irq) |-> ($past(step) || $past(reg_wr)));

endmodule

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
   localparam int TPS = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       alarm_irq, timer_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bcd_rtc_core #(.TICKS_PER_SEC(TPS), .ADDR_W(8)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .alarm_irq (alarm_irq),
      .timer_irq (timer_irq)
   );

   // {start yr,mon,day,hr,min,sec , expected yr,mon,day,hr,min,sec}
   localparam logic [95:0] VEC [10] = '{
      96'h00_01_01_00_00_00_00_01_01_00_00_01,
      96'h00_01_01_00_12_59_00_01_01_00_13_00,
      96'h24_06_15_23_59_59_24_06_16_00_00_00,
      96'h21_04_30_23_59_59_21_05_01_00_00_00,
      96'h24_02_28_23_59_59_24_02_29_00_00_00,
      96'h23_02_28_23_59_59_23_03_01_00_00_00,
      96'h00_02_29_23_59_59_00_03_01_00_00_00,
      96'h99_12_31_23_59_59_00_01_01_00_00_00,
      96'h19_01_31_23_59_59_19_02_01_00_00_00,
      96'h05_09_09_09_59_59_05_09_09_10_00_00
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic set_time(input logic [47:0] t);
      for (int f = 0; f < 6; f++) wr(8'(4 * f), t[8*f +: 8]);
   endtask

   task finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      logic [7:0] s0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values, R10 power-up flag
      rd(8'h00, v); check("R1 reset sec", v, 8'h00);
      rd(8'h04, v); check("R1 reset min", v, 8'h00);
      rd(8'h08, v); check("R1 reset hr", v, 8'h00);
      rd(8'h0C, v); check("R1 reset day", v, 8'h01);
      rd(8'h10, v); check("R1 reset mon", v, 8'h01);
      rd(8'h14, v); check("R1 reset yr", v, 8'h00);
      rd(8'h44, v); check("R10 reset status", v, 8'h80);

      // R9 writing zero keeps, writing one clears; RO bits ignored
      wr(8'h44, 8'h03); rd(8'h44, v); check("R9 zero write keeps", v, 8'h80);
      wr(8'h44, 8'h80); rd(8'h44, v); check("R9 w1c power-up", v, 8'h00);

      // R1 alarm readback
      wr(8'h2C, 8'h17); rd(8'h2C, v); check("R1 alarm day readback", v, 8'h17);

      // R2 stopped clock holds
      set_time(48'h00_01_01_00_00_10);
      ticks(2 * TPS);
      rd(8'h00, v); check("R2 stopped holds", v, 8'h10);
      rd(8'h44, v); check("R2 run bit clear", v, 8'h00);
      wr(8'h40, 8'h01);
      rd(8'h44, v); check("R2 run bit set", v, 8'h02);

      // R3 / R4 table walk
      foreach (VEC[k]) begin
         set_time(VEC[k][95:48]);
         ticks(TPS);
         for (int f = 0; f < 6; f++) begin
            rd(8'(4 * f), v);
            check((k >= 3 && k <= 8) ? "R4 month length" : "R3 rollover", v, VEC[k][8*f +: 8]);
         end
      end

      // R6 busy and R2 step spacing
      set_time(48'h00_01_01_00_00_20);
      wr(8'h44, 8'hC4);
      ticks(TPS - 1);
      rd(8'h44, v); check("R6 busy before step", v, 8'h03);
      rd(8'h00, v); check("R2 no step yet", v, 8'h20);
      wr(8'h40, 8'h00);
      rd(8'h44, v); check("R6 busy low when stopped", v, 8'h00);
      wr(8'h40, 8'h01);
      ticks(1);
      rd(8'h44, v); check("R6 busy low after step, R8 event", v, 8'h06);
      rd(8'h00, v); check("R2 step after count", v, 8'h21);

      // R5 write on the step edge
      set_time(48'h00_01_01_00_00_59);
      ticks(TPS - 1);
      @(negedge clk);
      tick_en = 1'b1; reg_addr = 8'h00; reg_wdata = 8'h30; reg_wr = 1'b1;
      @(negedge clk);
      tick_en = 1'b0; reg_wr = 1'b0;
      rd(8'h00, v); check("R5 written sec wins", v, 8'h30);
      rd(8'h04, v); check("R5 minute still carries", v, 8'h01);

      // R7 mismatch in year only
      wr(8'h20, 8'h05); wr(8'h24, 8'h00); wr(8'h28, 8'h00);
      wr(8'h2C, 8'h01); wr(8'h30, 8'h01); wr(8'h34, 8'h01);
      set_time(48'h00_01_01_00_00_04);
      wr(8'h44, 8'hC4);
      ticks(TPS);
      rd(8'h44, v); check("R7 year mismatch no alarm", v, 8'h06);

      // R7 exact match
      wr(8'h34, 8'h00);
      set_time(48'h00_01_01_00_00_04);
      wr(8'h44, 8'hC4);
      ticks(TPS);
      rd(8'h44, v); check("R7 alarm on match", v, 8'h46);

      // R11 interrupt gating
      wr(8'h48, 8'h08);
      #1 check("R11 alarm irq enabled", {7'b0, alarm_irq}, 8'h01);
      check("R11 timer irq disabled", {7'b0, timer_irq}, 8'h00);
      wr(8'h48, 8'h0C);
      #1 check("R11 timer irq enabled", {7'b0, timer_irq}, 8'h01);
      wr(8'h44, 8'h40);
      #1 check("R9 alarm cleared irq low", {7'b0, alarm_irq}, 8'h00);
      check("R9 sec event kept", {7'b0, timer_irq}, 8'h01);
      wr(8'h44, 8'h04);
      #1 check("R9 sec event cleared", {7'b0, timer_irq}, 8'h00);

      // R2 stop again
      wr(8'h40, 8'h00);
      rd(8'h00, s0);
      ticks(2 * TPS);
      rd(8'h00, v); check("R2 stop holds time", v, s0);

      finish_run();
   end

endmodule